// File: doc/BRIEF.md
# Clock-Low Stall Watchdog

This block watches the serial clock line of a two-wire bus controller and flags the bus as stalled when the line stays low for too long. The controller supplies the sampled clock level and a one-cycle tick for each bus clock period. The block counts the ticks for which the line is seen low. When the count reaches a programmable 20-bit limit, it latches a timeout status bit. An enable bit gates that status onto an interrupt output. Software clears the status by writing a one to a separate clear strobe. The block does not abort the transfer; the surrounding controller or software does that.

A limit of zero switches detection off. Because the limit reads back unchanged, software can report the stall length as the programmed value. The count is held by a small state machine with four states. `ST_OFF` means the limit is zero. `ST_HIGH` means the line is high and the count is cleared. `ST_LOW` means ticks are being counted while the line is low. `ST_EXPIRED` means the limit was reached during the current low phase.

The transitions are as follows:
- Any state goes to `ST_OFF` when the limit is zero.
- Any state goes to `ST_HIGH` when the line is high.
- `ST_OFF`, `ST_HIGH` and `ST_LOW` go to `ST_LOW` on a low cycle whose tick does not reach the limit.
- The same three states go to `ST_EXPIRED` on the tick that reaches the limit, which also raises the internal expire pulse.
- `ST_EXPIRED` holds while the line stays low.

Top module: `scl_low_watchdog`

## Requirements
- R1: After reset the limit reads 0, the interrupt enable reads 0, and both the timeout status and the interrupt output are 0.
- R2: A write on `limit_we` stores all 20 bits of `limit_wdata`, and `limit_rdata` shows the stored value from the next cycle on.
- R3: While the stored limit is 0, the timeout status never becomes set, however long the clock line stays low.
- R4: With a nonzero limit N, the status sets on the clock edge that takes the N-th `bit_tick` seen during one continuous low phase of `scl_level`. It is visible from the following cycle.
- R5: Any cycle with `scl_level` high clears the low-tick count, so ticks before and after a high pulse never add up.
- R6: Once set, the status stays set until it is cleared, even after the clock line returns high.
- R7: A cycle with `clr_we` high and `clr_wdata` high clears the status on the next edge.
- R8: When a clear and a new timeout event fall in the same cycle, the event wins and the status stays set.
- R9: `irq_out` is high exactly when the status is set and the stored enable bit is 1; the enable is written through `irq_en_we`/`irq_en_wdata` and reads back on `irq_en`.
- R10: The status bit sets on a timeout whether the interrupt enable is 0 or 1.
- R11: After a timeout, no further event occurs until `scl_level` has been seen high, so clearing the status while the line is still low leaves it clear.
- R12: A clear strobe with `clr_wdata` at 0 leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_level | input | 1 | Sampled level of the bus clock line |
| bit_tick | input | 1 | One-cycle pulse per bus clock period |
| limit_we | input | 1 | Write strobe for the limit |
| limit_wdata | input | 20 | New limit value, in bus clock periods; 0 disables detection |
| limit_rdata | output | 20 | Stored limit |
| irq_en_we | input | 1 | Write strobe for the interrupt enable |
| irq_en_wdata | input | 1 | New interrupt enable value |
| irq_en | output | 1 | Stored interrupt enable |
| clr_we | input | 1 | Clear strobe |
| clr_wdata | input | 1 | Clear data; 1 clears the status |
| timeout_status | output | 1 | Latched timeout status |
| irq_out | output | 1 | Timeout status gated by the enable |

## Verification
Every registered result is due one clock edge after the cycle that causes it. This covers the limit and enable readback, and the set and clear of the status on the tick that reaches the limit. `irq_out` follows the status and the enable with no extra register. The bench changes inputs on the falling edge and advances a reference model by one step for those inputs. It then compares all outputs at the next falling edge, so every comparison lands on the cycle in which the result is due. Directed sequences count ticks against the stated limit: they check the cycle before the limit is reached, the cycle it is reached, and the cycles after a clear during a still-low line.

// File: rtl/sclto_pkg.sv
package sclto_pkg;
    localparam int DEF_LIMIT_W = 20;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_HIGH    = 2'd1,
        ST_LOW     = 2'd2,
        ST_EXPIRED = 2'd3
    } wd_state_t;
endpackage

// File: rtl/sclto_cfg_regs.sv
module sclto_cfg_regs #(
    parameter int LIMIT_W = sclto_pkg::DEF_LIMIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               limit_we,
    input  logic [LIMIT_W-1:0] limit_wdata,
    input  logic               en_we,
    input  logic               en_wdata,
    output logic [LIMIT_W-1:0] limit_q,
    output logic               en_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (limit_we) begin
            limit_q <= limit_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_we) begin
            en_q <= en_wdata;
        end
    end
endmodule

// File: rtl/sclto_low_counter.sv
module sclto_low_counter #(
    parameter int LIMIT_W = sclto_pkg::DEF_LIMIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_level,
    input  logic               bit_tick,
    input  logic [LIMIT_W-1:0] limit,
    output logic               expire
);
    import sclto_pkg::*;

    localparam int SUM_W = LIMIT_W + 1;

    wd_state_t          st_q, st_n;
    logic [LIMIT_W-1:0] cnt_q, cnt_n;
    logic [SUM_W-1:0]   cnt_inc;
    logic               lim_off;
    logic               reach;

    assign cnt_inc = {1'b0, cnt_q} + {{LIMIT_W{1'b0}}, 1'b1};
    assign lim_off = (limit == '0);
    assign reach   = (cnt_inc >= {1'b0, limit});

    // next state and count
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            ST_EXPIRED: begin
                if (lim_off) begin
                    st_n  = ST_OFF;
                    cnt_n = '0;
                end else if (scl_level) begin
                    st_n  = ST_HIGH;
                    cnt_n = '0;
                end
            end
            ST_OFF, ST_HIGH, ST_LOW: begin
                if (lim_off) begin
                    st_n  = ST_OFF;
                    cnt_n = '0;
                end else if (scl_level) begin
                    st_n  = ST_HIGH;
                    cnt_n = '0;
                end else if (bit_tick && reach) begin
                    st_n  = ST_EXPIRED;
                    cnt_n = '0;
                end else if (bit_tick) begin
                    st_n  = ST_LOW;
                    cnt_n = cnt_inc[LIMIT_W-1:0];
                end else begin
                    st_n  = ST_LOW;
                end
            end
            default: begin
                st_n  = ST_OFF;
                cnt_n = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        expire = 1'b0;
        unique case (st_q)
            ST_OFF, ST_HIGH, ST_LOW:
                expire = !lim_off && !scl_level && bit_tick && reach;
            ST_EXPIRED:
                expire = 1'b0;
            default:
                expire = 1'b0;
        endcase
    end
endmodule

// File: rtl/sclto_event_latch.sv
module sclto_event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_we,
    input  logic clr_wdata,
    input  logic en_q,
    output logic status_q,
    output logic irq
);
    logic clr_hit;
    assign clr_hit = clr_we && clr_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (expire) begin
            status_q <= 1'b1;
        end else if (clr_hit) begin
            status_q <= 1'b0;
        end
    end

    assign irq = status_q && en_q;
endmodule

// File: rtl/scl_low_watchdog.sv
module scl_low_watchdog #(
    parameter int LIMIT_W = sclto_pkg::DEF_LIMIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_level,
    input  logic               bit_tick,
    input  logic               limit_we,
    input  logic [LIMIT_W-1:0] limit_wdata,
    output logic [LIMIT_W-1:0] limit_rdata,
    input  logic               irq_en_we,
    input  logic               irq_en_wdata,
    output logic               irq_en,
    input  logic               clr_we,
    input  logic               clr_wdata,
    output logic               timeout_status,
    output logic               irq_out
);
    logic [LIMIT_W-1:0] limit_q;
    logic               en_q;
    logic               expire;

    sclto_cfg_regs #(.LIMIT_W(LIMIT_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .limit_we    (limit_we),
        .limit_wdata (limit_wdata),
        .en_we       (irq_en_we),
        .en_wdata    (irq_en_wdata),
        .limit_q     (limit_q),
        .en_q        (en_q)
    );

    sclto_low_counter #(.LIMIT_W(LIMIT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_level (scl_level),
        .bit_tick  (bit_tick),
        .limit     (limit_q),
        .expire    (expire)
    );

    sclto_event_latch u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .en_q      (en_q),
        .status_q  (timeout_status),
        .irq       (irq_out)
    );

    assign limit_rdata = limit_q;
    assign irq_en      = en_q;
endmodule

// File: rtl/sclto_chk.sv
module sclto_chk #(
    parameter int LIMIT_W = sclto_pkg::DEF_LIMIT_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_level,
    input logic               limit_we,
    input logic [LIMIT_W-1:0] limit_wdata,
    input logic [LIMIT_W-1:0] limit_rdata,
    input logic               irq_en,
    input logic               clr_we,
    input logic               clr_wdata,
    input logic               expire,
    input logic               timeout_status,
    input logic               irq_out
);
    a_r2_limit_readback: assert property (@(posedge clk) disable iff (!rst_n)
        limit_we |=> (limit_rdata == $past(limit_wdata)));

    a_r3_zero_limit_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_rdata == '0 && !timeout_status) |=> !timeout_status);

    a_r5_high_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        scl_level |-> !expire);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_status && !(clr_we && clr_wdata)) |=> timeout_status);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_status && clr_we && clr_wdata && !expire) |=> !timeout_status);

    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> timeout_status);

    a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_out);
endmodule

bind scl_low_watchdog sclto_chk #(.LIMIT_W(LIMIT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_level      (scl_level),
    .limit_we       (limit_we),
    .limit_wdata    (limit_wdata),
    .limit_rdata    (limit_rdata),
    .irq_en         (irq_en),
    .clr_we         (clr_we),
    .clr_wdata      (clr_wdata),
    .expire         (expire),
    .timeout_status (timeout_status),
    .irq_out        (irq_out)
);

// File: tb/sim_scl_low_watchdog.sv
`timescale 1ns/1ps
module sim_scl_low_watchdog;
    localparam int LW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_level = 1'b1;
    logic          bit_tick = 1'b0;
    logic          limit_we = 1'b0;
    logic [LW-1:0] limit_wdata = '0;
    logic [LW-1:0] limit_rdata;
    logic          irq_en_we = 1'b0;
    logic          irq_en_wdata = 1'b0;
    logic          irq_en;
    logic          clr_we = 1'b0;
    logic          clr_wdata = 1'b0;
    logic          timeout_status;
    logic          irq_out;

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [LW-1:0] m_lim = '0;
    int            m_cnt = 0;
    bit            m_exp = 1'b0;
    bit            m_sts = 1'b0;
    bit            m_en  = 1'b0;

    always #10 clk = ~clk;

    scl_low_watchdog #(.LIMIT_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_level(scl_level), .bit_tick(bit_tick),
        .limit_we(limit_we), .limit_wdata(limit_wdata), .limit_rdata(limit_rdata),
        .irq_en_we(irq_en_we), .irq_en_wdata(irq_en_wdata), .irq_en(irq_en),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .timeout_status(timeout_status), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model_step();
        bit ev;
        ev = 1'b0;
        if (m_lim == '0 || scl_level) begin
            m_cnt = 0;
            m_exp = 1'b0;
        end else if (!m_exp && bit_tick) begin
            if (m_cnt + 1 >= int'(m_lim)) begin
                ev = 1'b1;
                m_exp = 1'b1;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
        m_sts = ev | (m_sts & !(clr_we & clr_wdata));
        if (limit_we)  m_lim = limit_wdata;
        if (irq_en_we) m_en  = irq_en_wdata;
    endfunction

    task automatic compare_all();
        chk("R2 limit", 32'(limit_rdata), 32'(m_lim));
        chk("R9 enable", 32'(irq_en), 32'(m_en));
        chk("R4 status", 32'(timeout_status), 32'(m_sts));
        chk("R9 irq", 32'(irq_out), 32'(m_sts & m_en));
    endtask

    // one cycle: inputs already set at a falling edge
    task automatic cyc();
        model_step();
        @(negedge clk);
        compare_all();
        limit_we = 1'b0; irq_en_we = 1'b0; clr_we = 1'b0; clr_wdata = 1'b0;
        bit_tick = 1'b0;
    endtask

    task automatic set_limit(input logic [LW-1:0] v);
        limit_we = 1'b1; limit_wdata = v; cyc();
    endtask

    task automatic set_en(input bit v);
        irq_en_we = 1'b1; irq_en_wdata = v; cyc();
    endtask

    task automatic low_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            scl_level = 1'b0; bit_tick = 1'b1; cyc();
        end
    endtask

    task automatic do_clear(input bit d);
        clr_we = 1'b1; clr_wdata = d; cyc();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'h1c5eed));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 limit", 32'(limit_rdata), 0);
        chk("R1 enable", 32'(irq_en), 0);
        chk("R1 status", 32'(timeout_status), 0);
        chk("R1 irq", 32'(irq_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 full-width readback
        set_limit(20'hFFFFF);
        chk("R2 max", 32'(limit_rdata), 32'hFFFFF);
        set_limit(20'hA5A5A);
        chk("R2 pattern", 32'(limit_rdata), 32'hA5A5A);

        // R3 zero limit disables
        set_limit('0);
        low_ticks(40);
        chk("R3 zero limit", 32'(timeout_status), 0);
        scl_level = 1'b1; cyc();

        // R4 exact count with limit 5, enable off (R10)
        set_limit(20'd5);
        low_ticks(4);
        chk("R4 before limit", 32'(timeout_status), 0);
        low_ticks(1);
        chk("R4 at limit", 32'(timeout_status), 1);
        chk("R10 status without enable", 32'(timeout_status), 1);
        chk("R9 irq masked", 32'(irq_out), 0);
        set_en(1'b1);
        chk("R9 irq enabled", 32'(irq_out), 1);

        // R6 sticky after release, R12 zero-data clear ignored
        scl_level = 1'b1; cyc(); cyc();
        chk("R6 sticky", 32'(timeout_status), 1);
        do_clear(1'b0);
        chk("R12 ignored clear", 32'(timeout_status), 1);
        do_clear(1'b1);
        chk("R7 clear", 32'(timeout_status), 0);

        // R11 no re-fire while still low
        low_ticks(5);
        chk("R11 fired", 32'(timeout_status), 1);
        scl_level = 1'b0; do_clear(1'b1);
        low_ticks(12);
        chk("R11 no refire", 32'(timeout_status), 0);
        scl_level = 1'b1; cyc();
        low_ticks(5);
        chk("R11 rearmed", 32'(timeout_status), 1);
        scl_level = 1'b1; do_clear(1'b1);

        // R5 high pulse splits count
        low_ticks(3);
        scl_level = 1'b1; cyc();
        low_ticks(3);
        chk("R5 split count", 32'(timeout_status), 0);
        scl_level = 1'b1; cyc();

        // R8 event beats clear; limit 1
        set_limit(20'd1);
        low_ticks(1);
        scl_level = 1'b1; cyc();
        chk("R4 limit one", 32'(timeout_status), 1);
        scl_level = 1'b0; bit_tick = 1'b1; clr_we = 1'b1; clr_wdata = 1'b1; cyc();
        chk("R8 event wins", 32'(timeout_status), 1);
        scl_level = 1'b1; do_clear(1'b1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            scl_level = ($urandom % 100) < 12;
            bit_tick  = ($urandom % 100) < 45;
            if (($urandom % 100) < 2) begin
                limit_we = 1'b1; limit_wdata = LW'($urandom % 9);
            end
            if (($urandom % 100) < 3) begin
                irq_en_we = 1'b1; irq_en_wdata = 1'($urandom);
            end
            if (($urandom % 100) < 5) begin
                clr_we = 1'b1; clr_wdata = 1'($urandom);
            end
            cyc();
        end
        summary();
    end
endmodule